// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the byte-wide register file that a host processor sees when it talks to a cartridge coprocessor. The host presents a bus address with a read or write strobe. The block folds that address into a 64-byte window and serves the access in the same cycle. Most offsets are plain storage. A small set of offsets have side effects:

- reading the decompression data port counts down a 16-bit transfer counter;
- writing the start registers launches the decompression, multiply and divide engines and raises their busy flags;
- writing the data-port registers asks for a data fetch;
- several registers keep only some of their bits.

The engines themselves sit outside this block. The block gives them one-cycle start pulses and the full register contents. The engines report back through done and ready strobes.

Reads are combinational on the current address. Every side effect takes hold at the clock edge that ends the access cycle. The start pulses are registered and are high during the cycle after the triggering write.

Top module: `copro_regwin`

## Requirements
- R1: The register offset is the low 6 bits of `bus_addr`. Any access whose top 8 address bits equal the data-bank value (0x50 by default) is forced to offset 0x00.
- R2: A read of offset 0x00 returns `dcmp_byte`. At the end of that cycle it decrements the 16-bit counter whose low byte is offset 0x09 and whose high byte is offset 0x0A. The counter wraps from 0x0000 to 0xFFFF.
- R3: Offset 0x08 and offset 0x1A always read 0x00, and writes to offset 0x08 change nothing.
- R4: A write to offset 0x06 stores the byte, clears bit 7 of the decompression status at offset 0x0C, and drives `dcmp_start` high for the next cycle. `dcmp_ready` sets that bit 7. If the write and `dcmp_ready` come in the same cycle, the write wins. A write to offset 0x04 drives `ldadr_start` high for the next cycle.
- R5: Write masks: offset 0x0B keeps bits [1:0], offset 0x18 keeps bits [6:0], offset 0x2E keeps bit 0, offset 0x30 keeps bits 7 and [2:0], and offsets 0x31 to 0x34 keep bits [2:0].
- R6: A write to offset 0x25 stores the byte, sets bits 7 and 0 of the arithmetic status at offset 0x2F, and drives `mul_start` high for the next cycle. A write to offset 0x27 stores the byte, sets bit 7 of offset 0x2F, and drives `div_start` high for the next cycle.
- R7: `mul_done` clears bits 7 and 0 of offset 0x2F, and `div_done` clears bit 7. When a start write to 0x25 or 0x27 comes in the same cycle as a done strobe, the bits set by the write stay set.
- R8: A write to offset 0x13 or offset 0x18 drives `port_fetch` high for the next cycle. A write to offset 0x15 does so only when bit 1 of offset 0x18, as held before that write, is 1.
- R9: After reset, every register reads 0x00 except offset 0x32, which reads 0x01, and offset 0x33, which reads 0x02. All pulse outputs are low.
- R10: Reads of offsets outside the implemented set return `open_bus`. The implemented set is 0x00–0x0C, 0x10–0x18, 0x1A and 0x20–0x34. Host writes to the status offsets 0x0C and 0x2F change nothing.
- R11: A byte written to a plain storage offset (for example 0x01) reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host bus address |
| rd_en | input | 1 | Host read strobe for this cycle |
| wr_en | input | 1 | Host write strobe for this cycle |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Read byte (combinational) |
| open_bus | input | 8 | Last bus value, returned for unimplemented offsets |
| dcmp_byte | input | 8 | Next byte from the decompression output |
| dcmp_ready | input | 1 | Decompression engine sets status bit 7 at 0x0C |
| mul_done | input | 1 | Multiply engine finished |
| div_done | input | 1 | Divide engine finished |
| dcmp_start | output | 1 | One-cycle decompression start |
| ldadr_start | output | 1 | One-cycle load-address request |
| mul_start | output | 1 | One-cycle multiply start |
| div_start | output | 1 | One-cycle divide start |
| port_fetch | output | 1 | One-cycle data-port fetch request |
| reg_image | output | 512 | All 64 registers, offset n at bits [8n+7:8n] |

## Verification
The bench drives the counter through zero so that it must wrap to 0xFFFF. A design with a narrow or saturating counter would read back 0x00 or keep a stale high byte. It makes a start write land in the same cycle as `dcmp_ready` or a done strobe. A design that gave the engine priority would show a cleared or set status bit where the host's choice must stand. It checks the conditional fetch on 0x15 both with bit 1 of 0x18 set and with it clear, and after each change of that bit. A design that tested the wrong bit, or the new value instead of the held one, would pulse `port_fetch` when it must stay low. The bench also reaches offset 0 through the data bank with unrelated low bits, writes to masked, read-only and dead offsets, and reads holes in the map. An unfolded address, a missing mask or a write-enabled status register would each read back the wrong byte.

// File: rtl/copro_regwin_pkg.sv
package copro_regwin_pkg;

    localparam int OFS_W = 6;
    localparam int NREG  = 1 << OFS_W;
    localparam int DW    = 8;

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [DW-1:0]    byte_t;

    localparam ofs_t O_DPORT   = 6'h00;
    localparam ofs_t O_LDADR   = 6'h04;
    localparam ofs_t O_DGO     = 6'h06;
    localparam ofs_t O_DEAD    = 6'h08;
    localparam ofs_t O_CNT_LO  = 6'h09;
    localparam ofs_t O_CNT_HI  = 6'h0A;
    localparam ofs_t O_DSTAT   = 6'h0C;
    localparam ofs_t O_PFETCH  = 6'h13;
    localparam ofs_t O_PSTEP   = 6'h15;
    localparam ofs_t O_PCTRL   = 6'h18;
    localparam ofs_t O_PSKIP   = 6'h1A;
    localparam ofs_t O_MULGO   = 6'h25;
    localparam ofs_t O_DIVGO   = 6'h27;
    localparam ofs_t O_ASTAT   = 6'h2F;

    typedef struct packed {
        logic dcmp;
        logic ldadr;
        logic mul;
        logic div;
        logic fetch;
    } trig_t;

    function automatic logic reg_readable(input ofs_t o);
        return (o <= 6'h0C) || (o >= 6'h10 && o <= 6'h18) ||
               (o == O_PSKIP) || (o >= 6'h20 && o <= 6'h34);
    endfunction

    function automatic logic reg_writable(input ofs_t o);
        return (o >= 6'h01 && o <= 6'h07) || (o >= 6'h09 && o <= 6'h0B) ||
               (o >= 6'h11 && o <= 6'h18) || (o >= 6'h20 && o <= 6'h27) ||
               (o == 6'h2E) || (o >= 6'h30 && o <= 6'h34);
    endfunction

    function automatic byte_t wr_mask(input ofs_t o);
        byte_t m;
        case (o)
            6'h0B:                      m = 8'h03;
            6'h18:                      m = 8'h7F;
            6'h2E:                      m = 8'h01;
            6'h30:                      m = 8'h87;
            6'h31, 6'h32, 6'h33, 6'h34: m = 8'h07;
            default:                    m = 8'hFF;
        endcase
        return m;
    endfunction

    function automatic byte_t reg_reset(input ofs_t o);
        byte_t v;
        case (o)
            6'h32:   v = 8'h01;
            6'h33:   v = 8'h02;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/copro_regwin_fold.sv
module copro_regwin_fold
    import copro_regwin_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [7:0]  DATA_BANK = 8'h50
) (
    input  logic [ADDR_W-1:0] addr,
    output ofs_t              ofs
);
    localparam int BANK_LSB = ADDR_W - 8;

    logic in_bank;

    always_comb begin
        in_bank = (addr[BANK_LSB +: 8] == DATA_BANK);
        ofs     = in_bank ? O_DPORT : addr[OFS_W-1:0];
    end
endmodule

// File: rtl/copro_regwin_trig.sv
module copro_regwin_trig
    import copro_regwin_pkg::*;
(
    input  logic  wr_en,
    input  ofs_t  ofs,
    input  logic  step_arm,
    output trig_t trig
);
    always_comb begin
        trig       = '0;
        trig.dcmp  = wr_en && (ofs == O_DGO);
        trig.ldadr = wr_en && (ofs == O_LDADR);
        trig.mul   = wr_en && (ofs == O_MULGO);
        trig.div   = wr_en && (ofs == O_DIVGO);
        trig.fetch = wr_en && ((ofs == O_PFETCH) || (ofs == O_PCTRL) ||
                               ((ofs == O_PSTEP) && step_arm));
    end
endmodule

// File: rtl/copro_regwin_rdmux.sv
module copro_regwin_rdmux
    import copro_regwin_pkg::*;
(
    input  ofs_t                 ofs,
    input  logic [NREG*DW-1:0]   image,
    input  byte_t                dcmp_byte,
    input  byte_t                open_bus,
    output byte_t                rd_data
);
    always_comb begin
        if (!reg_readable(ofs)) begin
            rd_data = open_bus;
        end else if (ofs == O_DPORT) begin
            rd_data = dcmp_byte;
        end else if (ofs == O_DEAD || ofs == O_PSKIP) begin
            rd_data = '0;
        end else begin
            rd_data = image[DW*ofs +: DW];
        end
    end
endmodule

// File: rtl/copro_regwin.sv
module copro_regwin
    import copro_regwin_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [7:0]  DATA_BANK = 8'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [7:0]        open_bus,
    input  logic [7:0]        dcmp_byte,
    input  logic              dcmp_ready,
    input  logic              mul_done,
    input  logic              div_done,
    output logic              dcmp_start,
    output logic              ldadr_start,
    output logic              mul_start,
    output logic              div_start,
    output logic              port_fetch,
    output logic [511:0]      reg_image
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        trig_t                   pulse;
    } state_t;

    state_t st_d, st_q;
    ofs_t   ofs;
    trig_t  trig;
    logic [2*DW-1:0] cnt_dec;

    copro_regwin_fold #(.ADDR_W(ADDR_W), .DATA_BANK(DATA_BANK)) u_fold (
        .addr (bus_addr),
        .ofs  (ofs)
    );

    copro_regwin_trig u_trig (
        .wr_en    (wr_en),
        .ofs      (ofs),
        .step_arm (st_q.regs[O_PCTRL][1]),
        .trig     (trig)
    );

    copro_regwin_rdmux u_rdmux (
        .ofs       (ofs),
        .image     (st_q.regs),
        .dcmp_byte (dcmp_byte),
        .open_bus  (open_bus),
        .rd_data   (rd_data)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = trig;
        cnt_dec    = {st_q.regs[O_CNT_HI], st_q.regs[O_CNT_LO]} - 1'b1;

        if (rd_en && ofs == O_DPORT) begin
            st_d.regs[O_CNT_LO] = cnt_dec[DW-1:0];
            st_d.regs[O_CNT_HI] = cnt_dec[2*DW-1:DW];
        end

        // engine strobes first, so a host write below overrides them
        if (dcmp_ready) st_d.regs[O_DSTAT][7] = 1'b1;
        if (mul_done) begin
            st_d.regs[O_ASTAT][7] = 1'b0;
            st_d.regs[O_ASTAT][0] = 1'b0;
        end
        if (div_done) st_d.regs[O_ASTAT][7] = 1'b0;

        if (wr_en) begin
            if (reg_writable(ofs)) st_d.regs[ofs] = wr_data & wr_mask(ofs);
            if (trig.dcmp) st_d.regs[O_DSTAT][7] = 1'b0;
            if (trig.mul)  st_d.regs[O_ASTAT] = st_d.regs[O_ASTAT] | 8'h81;
            if (trig.div)  st_d.regs[O_ASTAT] = st_d.regs[O_ASTAT] | 8'h80;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) st_q.regs[i] <= reg_reset(ofs_t'(i));
            st_q.pulse <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dcmp_start  = st_q.pulse.dcmp;
    assign ldadr_start = st_q.pulse.ldadr;
    assign mul_start   = st_q.pulse.mul;
    assign div_start   = st_q.pulse.div;
    assign port_fetch  = st_q.pulse.fetch;
    assign reg_image   = st_q.regs;
endmodule

// File: rtl/copro_regwin_chk.sv
module copro_regwin_chk #(
    parameter int          ADDR_W    = 24,
    parameter logic [7:0]  DATA_BANK = 8'h50
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [7:0]        rd_data,
    input logic              dcmp_start,
    input logic              mul_start,
    input logic              div_start,
    input logic              port_fetch,
    input logic [511:0]      reg_image
);
    logic [5:0]  a_ofs;
    logic [15:0] a_cnt;
    logic [7:0]  a_dstat, a_astat, a_dmode, a_pctrl, a_sign;

    assign a_ofs   = (bus_addr[ADDR_W-1 -: 8] == DATA_BANK) ? 6'h00 : bus_addr[5:0];
    assign a_cnt   = {reg_image[8*10 +: 8], reg_image[8*9 +: 8]};
    assign a_dstat = reg_image[8*12 +: 8];
    assign a_astat = reg_image[8*47 +: 8];
    assign a_dmode = reg_image[8*11 +: 8];
    assign a_pctrl = reg_image[8*24 +: 8];
    assign a_sign  = reg_image[8*46 +: 8];

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && a_ofs == 6'h00) |=> (a_cnt == $past(a_cnt) - 16'd1));

    // R3
    dead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && a_ofs == 6'h08) |-> (rd_data == 8'h00));

    // R4
    dcmp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dcmp_start |-> (a_dstat[7] == 1'b0));

    // R6
    mul_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> (a_astat[7] && a_astat[0]));

    // R6
    div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> a_astat[7]);

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_dmode[7:2] == 6'd0) && (a_sign[7:1] == 7'd0) && !a_pctrl[7]);

    // R8
    fetch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_fetch |-> $past(wr_en));
endmodule

bind copro_regwin copro_regwin_chk #(.ADDR_W(ADDR_W), .DATA_BANK(DATA_BANK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .dcmp_start (dcmp_start),
    .mul_start  (mul_start),
    .div_start  (div_start),
    .port_fetch (port_fetch),
    .reg_image  (reg_image)
);

// File: tb/copro_regwin_bench.sv
`timescale 1ns/1ps
module copro_regwin_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [7:0]  open_bus = 8'h3C;
    logic [7:0]  dcmp_byte = 8'hA5;
    logic        dcmp_ready = 1'b0, mul_done = 1'b0, div_done = 1'b0;
    logic        dcmp_start, ldadr_start, mul_start, div_start, port_fetch;
    logic [511:0] reg_image;

    always #2.5 clk = ~clk;

    copro_regwin u_copro_regwin (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .open_bus(open_bus), .dcmp_byte(dcmp_byte),
        .dcmp_ready(dcmp_ready), .mul_done(mul_done), .div_done(div_done),
        .dcmp_start(dcmp_start), .ldadr_start(ldadr_start), .mul_start(mul_start),
        .div_start(div_start), .port_fetch(port_fetch), .reg_image(reg_image)
    );

    localparam logic [4:0] T_N = 5'b00000, T_D = 5'b10000, T_L = 5'b01000,
                           T_M = 5'b00100, T_V = 5'b00010, T_F = 5'b00001;
    localparam logic [2:0] E_RDY = 3'b100, E_MUL = 3'b010, E_DIV = 3'b001;

    typedef struct {
        int         cyc;
        bit         is_rd;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare queued expectations in their due cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                item_t it;
                logic [7:0] obs;
                it = q.pop_front();
                obs = it.is_rd ? rd_data
                               : {3'b000, dcmp_start, ldadr_start, mul_start, div_start, port_fetch};
                checks++;
                if (obs !== it.exp || it.cyc != cyc) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", it.tag,
                             it.is_rd ? "read" : "pulses", obs, it.exp);
                end
            end
        end
    end

    task automatic acc(input bit we, input bit re, input logic [23:0] a, input logic [7:0] wd,
                       input logic [7:0] exp_rd, input logic [4:0] exp_tr,
                       input logic [2:0] ev, input string tag);
        item_t r, p;
        @(negedge clk);
        wr_en = we; rd_en = re; bus_addr = a; wr_data = wd;
        {dcmp_ready, mul_done, div_done} = ev;
        if (re) begin
            r = '{cyc, 1'b1, exp_rd, tag};
            q.push_back(r);
        end
        p = '{cyc + 1, 1'b0, {3'b000, exp_tr}, tag};
        q.push_back(p);
    endtask

    task automatic rd(input logic [5:0] o, input logic [7:0] e, input string tag);
        acc(1'b0, 1'b1, 24'h004800 | {18'd0, o}, 8'h00, e, T_N, 3'b000, tag);
    endtask

    task automatic wr(input logic [5:0] o, input logic [7:0] d, input logic [4:0] tr, input string tag);
        acc(1'b1, 1'b0, 24'h004800 | {18'd0, o}, d, 8'h00, tr, 3'b000, tag);
    endtask

    task automatic ev(input logic [2:0] e, input string tag);
        acc(1'b0, 1'b0, 24'h000000, 8'h00, 8'h00, T_N, e, tag);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset values
        rd(6'h32, 8'h01, "R9 bank2");
        rd(6'h33, 8'h02, "R9 bank3");
        rd(6'h31, 8'h00, "R9 bank1");
        rd(6'h2F, 8'h00, "R9 astat");
        rd(6'h09, 8'h00, "R9 cnt");

        // R2 counter countdown and wrap
        wr(6'h09, 8'h01, T_N, "R11 cnt lo");
        wr(6'h0A, 8'h00, T_N, "R11 cnt hi");
        rd(6'h00, 8'hA5, "R2 port byte");
        rd(6'h09, 8'h00, "R2 dec to zero");
        rd(6'h00, 8'hA5, "R2 port byte");
        rd(6'h09, 8'hFF, "R2 wrap lo");
        rd(6'h0A, 8'hFF, "R2 wrap hi");

        // R1 folding
        acc(1'b0, 1'b1, 24'h501234, 8'h00, 8'hA5, T_N, 3'b000, "R1 data bank to port");
        rd(6'h09, 8'hFE, "R1 bank read decrements");
        acc(1'b1, 1'b0, 24'h123481, 8'h5A, 8'h00, T_N, 3'b000, "R1 fold write");
        acc(1'b0, 1'b1, 24'h00FFC1, 8'h00, 8'h5A, T_N, 3'b000, "R1 R11 fold read");

        // R3 dead offsets
        wr(6'h08, 8'hFF, T_N, "R3 dead write");
        rd(6'h08, 8'h00, "R3 dead read");
        rd(6'h1A, 8'h00, "R3 skip read");

        // R10 holes and read-only status
        rd(6'h0D, 8'h3C, "R10 hole 0d");
        rd(6'h3F, 8'h3C, "R10 hole 3f");
        rd(6'h19, 8'h3C, "R10 hole 19");
        wr(6'h0C, 8'hFF, T_N, "R10 dstat write");
        rd(6'h0C, 8'h00, "R10 dstat ro");
        wr(6'h2F, 8'hFF, T_N, "R10 astat write");
        rd(6'h2F, 8'h00, "R10 astat ro");

        // R4 decompression start / status
        ev(E_RDY, "R4 ready");
        rd(6'h0C, 8'h80, "R4 ready sets bit7");
        wr(6'h06, 8'h12, T_D, "R4 dcmp start");
        rd(6'h0C, 8'h00, "R4 start clears bit7");
        rd(6'h06, 8'h12, "R4 R11 start stored");
        acc(1'b1, 1'b0, 24'h004806, 8'h34, 8'h00, T_D, E_RDY, "R4 write wins over ready");
        rd(6'h0C, 8'h00, "R4 write wins bit7");
        wr(6'h04, 8'h77, T_L, "R4 load addr");
        rd(6'h04, 8'h77, "R11 load addr stored");

        // R5 masks
        wr(6'h0B, 8'hFF, T_N, "R5 0b");
        rd(6'h0B, 8'h03, "R5 0b mask");
        wr(6'h2E, 8'hFF, T_N, "R5 2e");
        rd(6'h2E, 8'h01, "R5 2e mask");
        wr(6'h30, 8'hFF, T_N, "R5 30");
        rd(6'h30, 8'h87, "R5 30 mask");
        wr(6'h34, 8'hFF, T_N, "R5 34");
        rd(6'h34, 8'h07, "R5 34 mask");
        wr(6'h18, 8'hFF, T_F, "R5 R8 18 fetch");
        rd(6'h18, 8'h7F, "R5 18 mask");

        // R8 conditional fetch
        wr(6'h15, 8'h01, T_F, "R8 step armed");
        wr(6'h18, 8'h00, T_F, "R8 ctrl clear fetch");
        wr(6'h15, 8'h02, T_N, "R8 step disarmed");
        wr(6'h18, 8'h01, T_F, "R8 ctrl bit0 only");
        wr(6'h15, 8'h03, T_N, "R8 wrong bit");
        wr(6'h13, 8'h09, T_F, "R8 fetch reg");
        rd(6'h15, 8'h03, "R11 step stored");

        // R6 / R7 arithmetic starts and done
        wr(6'h25, 8'h11, T_M, "R6 mul start");
        rd(6'h2F, 8'h81, "R6 mul busy");
        rd(6'h25, 8'h11, "R6 mul operand");
        ev(E_MUL, "R7 mul done");
        rd(6'h2F, 8'h00, "R7 mul cleared");
        wr(6'h27, 8'h22, T_V, "R6 div start");
        rd(6'h2F, 8'h80, "R6 div busy");
        acc(1'b1, 1'b0, 24'h004825, 8'h33, 8'h00, T_M, E_DIV, "R7 write wins over done");
        rd(6'h2F, 8'h81, "R7 write wins value");
        ev(E_DIV, "R7 div done");
        rd(6'h2F, 8'h01, "R7 div clears bit7 only");
        ev(E_MUL, "R7 mul done 2");
        rd(6'h2F, 8'h00, "R7 all clear");

        ev(3'b000, "idle");
        repeat (4) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule